// File: doc/BRIEF.md
# Chip-Select Framed Serial Byte Receiver

This block is the receiving end of a three-wire synchronous serial link: a serial clock, a data line and an active-low frame select. While the frame select is low, the block samples the data line on every rising serial clock edge and shifts the bit into an internal register. The first bit it receives ends up as the most significant bit. Serial clock pulses that arrive while the frame select is high are ignored. Every falling edge of the frame select starts the bit position again from zero. A glitch on the serial clock can therefore corrupt at most the frame it falls in, and never shifts the alignment of later frames.

The block holds the finished byte in a separate clocked output register, so logic downstream never sees a partly shifted value. That register loads only when the frame select goes high after exactly eight sampled bits, and a one-cycle strobe marks each load. A frame that ends with fewer or more bits is discarded and leaves the output as it was. All three serial inputs pass through two-flop synchronizers into the system clock domain, and the system clock must run at least four times faster than the serial clock.

Control is a four-state machine:
- `ST_IDLE` (frame select high) moves to `ST_RECV` when the frame select falls; the bit counter and the shift register are cleared on that move.
- `ST_RECV` counts the sampled bits. It moves to `ST_FULL` when the eighth bit is sampled. It returns to `ST_IDLE` if the frame select rises before that, and the short frame is dropped.
- `ST_FULL` returns to `ST_IDLE` when the frame select rises, loading the output register and pulsing the strobe. A ninth serial clock edge instead moves it to `ST_SPILL`.
- `ST_SPILL` waits for the frame select to rise and then returns to `ST_IDLE` without loading.

Top module: `spi_frame_rx`

## Requirements
- R1: After reset, `rx_byte` is 0x00 and `rx_valid` is 0.
- R2: Within a frame, the data line is sampled on each rising edge of the serial clock, and the bits are shifted in so that the first bit sampled becomes bit 7 of `rx_byte` and the eighth becomes bit 0.
- R3: A frame of exactly eight serial clock pulses, closed by the frame select going high, updates `rx_byte` to the received byte within five system clock cycles of that rising edge.
- R4: `rx_byte` keeps its value between frames; it changes only in a cycle where `rx_valid` is high.
- R5: Serial clock pulses, and any data-line activity, while the frame select is high have no effect on the bit count or on `rx_byte`.
- R6: Each falling edge of the frame select resets the bit position, so a full frame received after a broken one is captured correctly.
- R7: A frame closed after fewer than eight pulses leaves `rx_byte` unchanged and raises no `rx_valid`.
- R8: A frame closed after more than eight pulses leaves `rx_byte` unchanged and raises no `rx_valid`.
- R9: `rx_valid` is high for exactly one system clock cycle per accepted frame. That cycle is the one in which `rx_byte` takes its new value, and it occurs only after the frame select has risen following eight counted bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from the master, sampled on its rising edge |
| mosi | input | 1 | Serial data from the master, most significant bit first |
| cs_n | input | 1 | Active-low frame select |
| rx_byte | output | 8 | Holding register with the last accepted byte |
| rx_valid | output | 1 | One-cycle strobe when rx_byte is loaded |

## Verification
The fixed bytes 0x55, 0xF0, 0xC0 and 0xC3 are sent first. Their alternating bits, nibble split and lopsided ends show up any mistake in bit order or a shift by one position. Serial clock bursts sent while the frame select is high, frames of five and ten bits, and a full frame sent right after a short one test the gating, the rejection of wrong-length frames and the realignment at each frame start. A seeded random run then mixes frames of six to ten bits with random contents. A bench model predicts the held byte and the number of strobes for each frame, which distinguishes accepted frames from discarded ones.

// File: rtl/spi_rx_pkg.sv
package spi_rx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RECV,
        ST_FULL,
        ST_SPILL
    } rx_state_t;
endpackage

// File: rtl/spi_rx_sync.sv
module spi_rx_sync #(
    parameter int          WIDTH   = 3,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] d_sync
);
    genvar gi;
    generate
        for (gi = 0; gi < WIDTH; gi++) begin : g_bit
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain <= {STAGES{RST_VAL[gi]}};
                end else begin
                    chain <= {chain[STAGES-2:0], d_async[gi]};
                end
            end
            assign d_sync[gi] = chain[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/spi_rx_edge.sv
module spi_rx_edge #(
    parameter int               WIDTH   = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] lvl,
    output logic [WIDTH-1:0] rise,
    output logic [WIDTH-1:0] fall
);
    logic [WIDTH-1:0] prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev <= RST_VAL;
        end else begin
            prev <= lvl;
        end
    end

    assign rise = lvl & ~prev;
    assign fall = ~lvl & prev;
endmodule

// File: rtl/spi_rx_fsm.sv
module spi_rx_fsm
    import spi_rx_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int CNT_W = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_rise,
    input  logic              cs_fall,
    input  logic              sck_rise,
    input  logic              data_bit,
    output logic [DATA_W-1:0] hold_q,
    output logic              hold_load,
    output logic [CNT_W-1:0]  bit_cnt
);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(DATA_W - 1);

    rx_state_t         state, state_nx;
    logic [DATA_W-1:0] shreg;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // transitions; frame-select release takes priority over a clock edge
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (cs_fall) state_nx = ST_RECV;
            ST_RECV: begin
                if (cs_rise)                             state_nx = ST_IDLE;
                else if (sck_rise && bit_cnt == LAST_IDX) state_nx = ST_FULL;
            end
            ST_FULL: begin
                if (cs_rise)       state_nx = ST_IDLE;
                else if (sck_rise) state_nx = ST_SPILL;
            end
            ST_SPILL: if (cs_rise) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg     <= '0;
            bit_cnt   <= '0;
            hold_q    <= '0;
            hold_load <= 1'b0;
        end else begin
            hold_load <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (cs_fall) begin
                        shreg   <= '0;
                        bit_cnt <= '0;
                    end
                end
                ST_RECV: begin
                    if (!cs_rise && sck_rise) begin
                        shreg   <= {shreg[DATA_W-2:0], data_bit};
                        bit_cnt <= bit_cnt + CNT_W'(1);
                    end
                end
                ST_FULL: begin
                    if (cs_rise) begin
                        hold_q    <= shreg;
                        hold_load <= 1'b1;
                    end
                end
                ST_SPILL: ;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/spi_frame_rx.sv
module spi_frame_rx #(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2,
    localparam int CNT_W      = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck,
    input  logic              mosi,
    input  logic              cs_n,
    output logic [DATA_W-1:0] rx_byte,
    output logic              rx_valid
);
    logic [2:0]       in_sync;
    logic             cs_lvl, sck_lvl, mosi_lvl;
    logic [1:0]       rise_v, fall_v;
    logic             cs_rise, cs_fall, sck_rise;
    logic [CNT_W-1:0] bit_cnt;

    spi_rx_sync #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b100)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_async({cs_n, sck, mosi}),
        .d_sync (in_sync)
    );

    assign cs_lvl   = in_sync[2];
    assign sck_lvl  = in_sync[1];
    assign mosi_lvl = in_sync[0];

    spi_rx_edge #(
        .WIDTH  (2),
        .RST_VAL(2'b10)
    ) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  ({cs_lvl, sck_lvl}),
        .rise (rise_v),
        .fall (fall_v)
    );

    assign cs_rise  = rise_v[1];
    assign cs_fall  = fall_v[1];
    assign sck_rise = rise_v[0];

    spi_rx_fsm #(
        .DATA_W(DATA_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_rise  (cs_rise),
        .cs_fall  (cs_fall),
        .sck_rise (sck_rise),
        .data_bit (mosi_lvl),
        .hold_q   (rx_byte),
        .hold_load(rx_valid),
        .bit_cnt  (bit_cnt)
    );
endmodule

// File: rtl/spi_frame_rx_chk.sv
module spi_frame_rx_chk #(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_lvl,
    input logic              cs_rise,
    input logic [CNT_W-1:0]  bit_cnt,
    input logic [DATA_W-1:0] rx_byte,
    input logic              rx_valid
);
    p_strobe_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    p_strobe_after_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(cs_rise));

    p_strobe_full_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> (bit_cnt == CNT_W'(DATA_W)));

    p_hold_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |=> $stable(rx_byte) || $rose(rx_valid));

    p_gate_when_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cs_lvl |=> $stable(bit_cnt));

    p_count_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= CNT_W'(DATA_W));

    always @(posedge clk) begin
        if (!rst_n) begin
            p_reset_clear_r1: assert (rx_valid == 1'b0);
        end
    end
endmodule

bind spi_frame_rx spi_frame_rx_chk #(
    .DATA_W(DATA_W),
    .CNT_W (CNT_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_lvl  (cs_lvl),
    .cs_rise (cs_rise),
    .bit_cnt (bit_cnt),
    .rx_byte (rx_byte),
    .rx_valid(rx_valid)
);

// File: tb/spi_frame_rx_test.sv
module spi_frame_rx_test;
    timeunit 1ns;
    timeprecision 1ps;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sck = 1'b0;
    logic       mosi = 1'b0;
    logic       cs_n = 1'b1;
    logic [7:0] rx_byte;
    logic       rx_valid;

    int n_chk = 0;
    int n_bad = 0;
    int vcnt  = 0;

    always #2 clk = ~clk;

    spi_frame_rx uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .sck     (sck),
        .mosi    (mosi),
        .cs_n    (cs_n),
        .rx_byte (rx_byte),
        .rx_valid(rx_valid)
    );

    always @(posedge clk) if (rx_valid) vcnt <= vcnt + 1;

    function automatic logic [7:0] model_byte(logic [7:0] prev, logic [15:0] bits, int n);
        return (n == 8) ? bits[7:0] : prev;
    endfunction

    function automatic int model_strobes(int n);
        return (n == 8) ? 1 : 0;
    endfunction

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(int n);
        repeat (n) @(negedge clk);
    endtask

    // serial clock half period = 4 system clocks
    task automatic send_frame(logic [15:0] bits, int n);
        cs_n = 1'b0;
        wait_clk(4);
        for (int i = n - 1; i >= 0; i--) begin
            mosi = bits[i];
            wait_clk(4);
            sck = 1'b1;
            wait_clk(4);
            sck = 1'b0;
        end
        wait_clk(4);
        cs_n = 1'b1;
        wait_clk(10);
    endtask

    task automatic frame_and_check(string req, logic [15:0] bits, int n);
        logic [7:0] exp_b;
        int v0;
        exp_b = model_byte(rx_byte, bits, n);
        v0 = vcnt;
        send_frame(bits, n);
        check(req, rx_byte, exp_b);
        check({req, "_strobe"}, vcnt - v0, model_strobes(n));
    endtask

    task automatic glitch_burst(int pulses);
        for (int i = 0; i < pulses; i++) begin
            mosi = $urandom() % 2;
            wait_clk(3);
            sck = 1'b1;
            wait_clk(3);
            sck = 1'b0;
        end
        wait_clk(8);
    endtask

    initial begin
        #800000;
        n_bad++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] keep;
        int v0;
        void'($urandom(32'd7));
        wait_clk(5);
        // R1 reset state
        check("R1_byte", rx_byte, 8'h00);
        check("R1_valid", rx_valid, 0);
        rst_n = 1'b1;
        wait_clk(5);
        check("R1_after", rx_byte, 8'h00);

        // R2 / R3 directed bytes, MSB first
        frame_and_check("R2_R3_55", 16'h0055, 8);
        frame_and_check("R2_R3_F0", 16'h00F0, 8);
        frame_and_check("R2_R3_C0", 16'h00C0, 8);
        frame_and_check("R2_R3_C3", 16'h00C3, 8);

        // R5 clock glitches with frame select high
        keep = rx_byte;
        v0 = vcnt;
        glitch_burst(9);
        check("R5_byte", rx_byte, keep);
        check("R5_strobe", vcnt - v0, 0);
        frame_and_check("R5_after", 16'h005A, 8);

        // R7 short frame, then R6 realignment
        frame_and_check("R7_short", 16'h001F, 5);
        frame_and_check("R6_realign", 16'h00A5, 8);

        // R8 long frame
        frame_and_check("R8_long", 16'h03C6, 10);
        frame_and_check("R6_after_long", 16'h0081, 8);

        // R4 holds between frames
        keep = rx_byte;
        wait_clk(60);
        check("R4_hold", rx_byte, keep);

        // R9 single strobe per accepted frame
        v0 = vcnt;
        send_frame(16'h00FF, 8);
        send_frame(16'h0000, 8);
        check("R9_two_frames", vcnt - v0, 2);
        check("R9_last", rx_byte, 8'h00);

        // random mix
        for (int k = 0; k < 24; k++) begin
            int n;
            logic [15:0] b;
            n = 6 + int'($urandom() % 5);
            if ($urandom() % 3 != 0) n = 8;
            b = 16'($urandom());
            if ($urandom() % 4 == 0) begin
                keep = rx_byte;
                glitch_burst(3);
                check("R5_rand", rx_byte, keep);
            end
            frame_and_check((n == 8) ? "R3_rand" : (n < 8 ? "R7_rand" : "R8_rand"), b, n);
        end

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule